// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and a 32K x 8 asynchronous static RAM. The host asks for one access at a time through a request/ready handshake, giving an address, a read/write flag and a write byte. The controller then runs a read or write sequence on the memory's active-low select, output-enable and write-strobe lines. It holds the address steady for the whole access and returns read bytes with a one-cycle valid strobe.

Every timing window is a whole number of clock cycles, rounded up from the memory's nanosecond minimums and a clock-period parameter. With a 10 ns clock, a read holds the memory selected and output-enabled for 10 cycles. A write holds select and write strobe low for 10 cycles. After each read the memory is deselected for 4 cycles so its output can float. Between accesses all three strobes sit high, which leaves the memory in low-power standby.

Write data leaves on a separate output bus, gated by its own driver-enable. Read data arrives on an input bus. The pad tri-state is built outside this block.

Top module: `async_sram_ctrl`

## Requirements
- R1: After reset, and at any time the controller is idle, `ready` is 1, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are all 1, `sram_dq_oe` is 0 and `rd_valid` is 0.
- R2: A read holds `sram_ce_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 for exactly RD_CYC consecutive cycles, which is 10 at the default 10 ns period. The write strobe never falls while output-enable is low.
- R3: A write holds `sram_ce_n`=0 and `sram_we_n`=0 with `sram_oe_n` fixed at 1 for exactly WR_CYC consecutive cycles, 10 by default. `ready` is 1 in the first cycle after the write strobe rises.
- R4: `rd_data` carries the value present on `sram_dq_in` in the last cycle of the read strobe, and `rd_valid` is 1 for exactly one cycle: the cycle after that last read cycle.
- R5: After every read, select and output-enable stay at 1 and the driver stays off for exactly TURN_CYC cycles (4 by default) before `ready` returns. The data driver is never enabled fewer than TURN_CYC cycles after output-enable was last low.
- R6: `sram_dq_oe` is 1 only while `sram_we_n` is 0 and `sram_oe_n` is 1. During a write, `sram_dq_out` equals the accepted write byte.
- R7: For the whole of an access, `sram_addr` equals the address accepted with that request and does not change.
- R8: A request is taken only in a cycle where `req` and `ready` are both 1, after which `ready` drops. A `req` raised while `ready` is 0 and withdrawn before `ready` returns starts no access and changes no memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Host access request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | Idle and able to accept a request |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| sram_addr | output | 15 | Memory address bus |
| sram_ce_n | output | 1 | Memory select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_dq_out | output | 8 | Data toward the memory |
| sram_dq_oe | output | 1 | Enable for the external data driver |
| sram_dq_in | input | 8 | Data from the memory |

## Verification
The hardest case to reach is a request that arrives while the controller is busy and is then withdrawn. The bench holds `req` high with a conflicting write for three cycles in the middle of a read. It then checks that no extra strobe pulse appears and that a later read of that address returns the old byte. The memory model in the bench drives the inverse of the stored byte until the read strobe has been held for its full length. A capture one cycle early therefore shows up as a wrong byte. A read followed at once by a write exercises the turnaround window.

// File: rtl/sram_ctl_pkg.sv
// Shared types and cycle-count helpers for the static RAM controller.
// Assumes all nanosecond figures and the clock period are positive integers.
package sram_ctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_TURN  = 2'd3
    } seq_state_e;

    // Round a nanosecond minimum up to whole clock cycles.
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_win_timer.sv
// Loadable down-counter that times one access window.
// Assumes load is a single-cycle pulse; zero is high once the loaded count has elapsed.
module sram_win_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] count;

    // Load a new window or count the running one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - 1'b1;
    end

    assign zero = (count == '0);
endmodule

// File: rtl/sram_seq.sv
// Access sequencer: decides the state of each cycle and registers the memory
// strobes for it, so they come straight from flops.
// Assumes RD_CYC, WR_CYC and TURN_CYC are all at least 1.
module sram_seq
    import sram_ctl_pkg::*;
#(
    parameter int RD_CYC   = 10,
    parameter int WR_CYC   = 10,
    parameter int TURN_CYC = 4,
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_wr,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             capture,
    output logic             ready,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             dq_oe
);
    seq_state_e state, nstate;
    logic       accept;

    assign accept = req && ready;

    // Next state, timer load and capture decision for the current cycle.
    always_comb begin
        nstate   = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        case (state)
            ST_IDLE: begin
                if (accept) begin
                    tmr_load = 1'b1;
                    if (req_wr) begin
                        nstate  = ST_WRITE;
                        tmr_val = CNT_W'(WR_CYC - 1);
                    end else begin
                        nstate  = ST_READ;
                        tmr_val = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_READ: begin
                if (tmr_zero) begin
                    capture  = 1'b1;
                    nstate   = ST_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(TURN_CYC - 1);
                end
            end
            ST_WRITE: begin
                if (tmr_zero)
                    nstate = ST_IDLE;
            end
            ST_TURN: begin
                if (tmr_zero)
                    nstate = ST_IDLE;
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // Advance the state and register the strobes that belong to the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ready <= 1'b1;
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            state <= nstate;
            ready <= (nstate == ST_IDLE);
            ce_n  <= !((nstate == ST_READ) || (nstate == ST_WRITE));
            oe_n  <= (nstate != ST_READ);
            we_n  <= (nstate != ST_WRITE);
            dq_oe <= (nstate == ST_WRITE);
        end
    end
endmodule

// File: rtl/sram_rd_capture.sv
// Read-data capture: samples the memory data bus on the capture pulse and
// raises a one-cycle valid strobe.
// Assumes the capture pulse marks the last cycle of the read strobe.
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    // Hold the sampled byte and flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture)
                rd_data <= dq_in;
        end
    end
endmodule

// File: rtl/async_sram_ctrl.sv
// Top of the asynchronous static RAM controller. It turns host requests into
// timed read and write strobe sequences. All windows are derived from
// CLK_PERIOD_NS. The data pad tri-state is external, driven by sram_dq_oe.
// Assumes one outstanding request at a time and a synchronous active-low reset.
module async_sram_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W         = 15,
    parameter int DATA_W         = 8,
    parameter int CLK_PERIOD_NS  = 10,
    parameter int RD_CYCLE_NS    = 100,
    parameter int ADDR_ACCESS_NS = 100,
    parameter int OE_ACCESS_NS   = 50,
    parameter int WR_CYCLE_NS    = 100,
    parameter int WE_PULSE_NS    = 80,
    parameter int CE_WRITE_NS    = 90,
    parameter int DATA_SETUP_NS  = 50,
    parameter int FLOAT_NS       = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    localparam int RD_CYC = imax(1, imax(ns_to_cyc(RD_CYCLE_NS, CLK_PERIOD_NS),
                                 imax(ns_to_cyc(ADDR_ACCESS_NS, CLK_PERIOD_NS),
                                      ns_to_cyc(OE_ACCESS_NS, CLK_PERIOD_NS))));
    localparam int WR_CYC = imax(imax(1, ns_to_cyc(WR_CYCLE_NS, CLK_PERIOD_NS)),
                                 imax(ns_to_cyc(WE_PULSE_NS, CLK_PERIOD_NS),
                                      imax(ns_to_cyc(CE_WRITE_NS, CLK_PERIOD_NS),
                                           ns_to_cyc(DATA_SETUP_NS, CLK_PERIOD_NS))));
    localparam int TURN_CYC = imax(1, ns_to_cyc(FLOAT_NS, CLK_PERIOD_NS));
    localparam int LONGEST  = imax(RD_CYC, imax(WR_CYC, TURN_CYC));
    localparam int CNT_W    = $clog2(LONGEST + 1);

    logic             tmr_load, tmr_zero, capture;
    logic [CNT_W-1:0] tmr_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // Latch address and write byte when a request is taken; hold them until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (req && ready) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    assign sram_addr   = addr_q;
    assign sram_dq_out = wdata_q;

    sram_win_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_seq #(
        .RD_CYC   (RD_CYC),
        .WR_CYC   (WR_CYC),
        .TURN_CYC (TURN_CYC),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_wr   (req_wr),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .capture  (capture),
        .ready    (ready),
        .ce_n     (sram_ce_n),
        .oe_n     (sram_oe_n),
        .we_n     (sram_we_n),
        .dq_oe    (sram_dq_oe)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .dq_in    (sram_dq_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/sram_ctl_chk.sv
// Protocol checker for the static RAM controller, bound to its top module.
// Assumes the same synchronous active-low reset as the design.
module sram_ctl_chk #(
    parameter int ADDR_W   = 15,
    parameter int TURN_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              ready,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              dq_oe,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] addr
);
    localparam int SW = $clog2(TURN_CYC + 1) + 1;
    logic [SW-1:0] since_oe;

    // Count cycles since output-enable was last low, saturating at the turnaround length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_oe <= SW'(TURN_CYC);
        else if (!oe_n)
            since_oe <= '0;
        else if (since_oe < SW'(TURN_CYC))
            since_oe <= since_oe + 1'b1;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (ce_n && oe_n && we_n && !dq_oe));

    p_we_high_in_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (we_n && !ce_n));

    p_oe_fixed_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> (oe_n && $stable(oe_n) && !ce_n));

    p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> (since_oe >= SW'(TURN_CYC)));

    p_drive_only_we_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!we_n && oe_n));

    p_addr_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && $past(!ce_n)) |-> $stable(addr));

    p_accept_drops_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready);
endmodule

bind async_sram_ctrl sram_ctl_chk #(.ADDR_W(ADDR_W), .TURN_CYC(TURN_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .ready    (ready),
    .ce_n     (sram_ce_n),
    .oe_n     (sram_oe_n),
    .we_n     (sram_we_n),
    .dq_oe    (sram_dq_oe),
    .rd_valid (rd_valid),
    .addr     (sram_addr)
);

// File: tb/tb_async_sram_ctrl.sv
module tb_async_sram_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int RD_CYC     = 10;
    localparam int WR_CYC     = 10;
    localparam int TURN_CYC   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_wr = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, rd_valid, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [7:0]  rd_data, sram_dq_out;
    logic [7:0]  sram_dq_in = '0;
    logic [14:0] sram_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct { bit wr; logic [14:0] a; logic [7:0] d; } op_t;
    op_t        op_q[$];
    logic [7:0] rd_q[$];
    logic [7:0] shadow [int];
    logic [7:0] mem    [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    async_sram_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] peek(input logic [7:0] arr [int], input int a);
        return arr.exists(a) ? arr[a] : 8'h00;
    endfunction

    // Memory model: drives the inverse of the stored byte until the read strobe has been held RD_CYC cycles.
    int acc = 0;
    always @(negedge clk) begin
        if (!sram_ce_n && !sram_oe_n && sram_we_n) acc = acc + 1;
        else acc = 0;
        if (!sram_ce_n && !sram_we_n) mem[int'(sram_addr)] = sram_dq_out;
        sram_dq_in = (acc >= RD_CYC) ? peek(mem, int'(sram_addr)) : ~peek(mem, int'(sram_addr));
    end

    // Driver: pushes the expected access and data, then presents the request for one cycle.
    task automatic issue(input bit wr, input logic [14:0] a, input logic [7:0] d);
        while (!ready) @(negedge clk);
        op_q.push_back('{wr, a, d});
        if (wr) shadow[int'(a)] = d;
        else    rd_q.push_back(peek(shadow, int'(a)));
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
    endtask

    // Monitor: checks strobe pulse lengths, addresses, turnaround and returned bytes.
    int rd_len = 0, wr_len = 0, turn_len = 0;
    bit in_turn = 0, prev_valid = 0;
    op_t cur;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
                if (rd_len == 0) begin
                    if (op_q.size() == 0) check(0, "R8 unexpected read", 1, 0);
                    else begin
                        cur = op_q.pop_front();
                        check(!cur.wr, "R2 read where write expected", 0, int'(cur.wr));
                        check(sram_addr == cur.a, "R7 read address", int'(sram_addr), int'(cur.a));
                    end
                end else if (sram_addr != cur.a) check(0, "R7 address moved in read", int'(sram_addr), int'(cur.a));
                rd_len++;
            end else if (rd_len > 0) begin
                check(rd_len == RD_CYC, "R2 read strobe length", rd_len, RD_CYC);
                rd_len = 0; in_turn = 1; turn_len = 0;
            end
            if (in_turn) begin
                if (ready) begin
                    check(turn_len == TURN_CYC, "R5 turnaround length", turn_len, TURN_CYC);
                    in_turn = 0;
                end else begin
                    if (!(sram_ce_n && sram_oe_n && !sram_dq_oe))
                        check(0, "R5 bus not released in turnaround", {sram_ce_n, sram_oe_n, sram_dq_oe}, 3'b110);
                    turn_len++;
                end
            end
            if (!sram_ce_n && !sram_we_n) begin
                if (wr_len == 0) begin
                    if (op_q.size() == 0) check(0, "R8 unexpected write", 1, 0);
                    else begin
                        cur = op_q.pop_front();
                        check(cur.wr, "R3 write where read expected", 1, int'(cur.wr));
                        check(sram_addr == cur.a, "R7 write address", int'(sram_addr), int'(cur.a));
                    end
                end
                if (!(sram_oe_n && sram_dq_oe && sram_dq_out == cur.d && sram_addr == cur.a))
                    check(0, "R6 write bus state", {sram_oe_n, sram_dq_oe, sram_dq_out}, {2'b11, cur.d});
                wr_len++;
            end else if (wr_len > 0) begin
                check(wr_len == WR_CYC, "R3 write strobe length", wr_len, WR_CYC);
                check(ready, "R3 ready right after write", int'(ready), 1);
                wr_len = 0;
            end
            if (sram_dq_oe && !(!sram_we_n && sram_oe_n))
                check(0, "R6 driver on outside write strobe", {sram_we_n, sram_oe_n}, 2'b01);
            if (rd_valid) begin
                check(!prev_valid, "R4 valid longer than one cycle", 1, 0);
                if (rd_q.size() == 0) check(0, "R4 unexpected read data", int'(rd_data), 0);
                else begin
                    logic [7:0] e;
                    e = rd_q.pop_front();
                    check(rd_data == e, "R4 read data", int'(rd_data), int'(e));
                end
            end
            prev_valid = rd_valid;
        end
    end

    task automatic settle();
        repeat (RD_CYC + TURN_CYC + 4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready && sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && !rd_valid,
              "R1 reset state", {ready, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, rd_valid}, 6'b111100);

        // Back-to-back writes at both ends of the address range.
        issue(1, 15'h0000, 8'h3C);
        issue(1, 15'h7FFF, 8'hC3);
        issue(0, 15'h0000, 8'h00);
        issue(0, 15'h7FFF, 8'h00);
        // Read of an unwritten cell followed at once by a write (turnaround).
        issue(0, 15'h1234, 8'h00);
        issue(1, 15'h1234, 8'h5A);
        issue(0, 15'h1234, 8'h00);
        settle();

        // R8: a request held while busy and withdrawn must be ignored.
        issue(0, 15'h0000, 8'h00);
        for (int k = 0; k < 3; k++) begin
            check(!ready, "R8 busy after accept", int'(ready), 0);
            req = 1'b1; req_wr = 1'b1; req_addr = 15'h0000; req_wdata = 8'hFF;
            @(negedge clk);
        end
        req = 1'b0;
        settle();
        check(op_q.size() == 0, "R8 no extra access", op_q.size(), 0);
        issue(0, 15'h0000, 8'h00);
        settle();

        // Spread of addresses and data patterns.
        for (int i = 0; i < 8; i++) issue(1, 15'((i * 4099) & 16'h7FFF), 8'(i * 37 + 1));
        for (int i = 0; i < 8; i++) issue(0, 15'((i * 4099) & 16'h7FFF), 8'h00);
        settle();

        check(ready && sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe,
              "R1 idle standby", {ready, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 5'b11110);
        check(op_q.size() == 0 && rd_q.size() == 0, "R4 all results returned",
              op_q.size() + rd_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule